// File: doc/BRIEF.md
# Dual-Core Shared Slot Controller

This block manages the per-slot state of one fully associative cache array that two processor cores share. Each core presents its own request: a valid strobe, a write flag, a line address and a flush command. The controller answers with a grant and a slot index, or it stalls the core by withholding the grant. It does not hold line data. When a modified line must leave the array, the controller raises a write-back request and waits for an acknowledge.

For every slot the controller keeps a valid bit, an address tag, a dirty bit, the core that owns the dirty data, and a lock bit together with the core that holds the lock. A granted access locks its slot. The lock holder releases it with a one-cycle `done` pulse. A modified line belongs only to the core that wrote it, and the other core treats it as absent. Two copies of one address can therefore exist, and these are resolved later by flush or eviction.

A requesting core holds its request steady until it sees its grant. The grant is combinational, so it is valid in the cycle before the clock edge that registers the new slot state. At most one request is served per cycle.

Top module: `shared_slot_ctrl`

## Requirements
- R1: After reset every slot is invalid and unlocked, no write-back is requested, no grant is given, and the first read request lands in slot 0.
- R2: A request whose address has no visible copy, made while an invalid unlocked slot exists, is granted in the cycle it is presented. It gets the lowest-numbered such slot. `grant_slot` carries the slot number in binary, and only the requesting core's grant bit rises.
- R3: A read that matches a clean line is granted that slot and leaves it clean, so two cores can read through one slot. A write that matches a clean line makes it dirty and owned by the writer.
- R4: A dirty line owned by one core is invisible to the other core. A request from the other core to that address misses and places a second copy in another slot.
- R5: When the chosen matching slot is locked, the requester gets no grant. The holder's `done` pulse releases the lock, and the stalled core is granted in the cycle after the pulse.
- R6: At most one core is granted per cycle. When both cores request, core 0 wins in the first cycle after reset, and the winning core alternates every cycle after that. The losing core is served in a later cycle.
- R7: On a miss with no invalid unlocked slot, the victim is the lowest-numbered unlocked valid slot. A clean victim is replaced and granted in the same cycle. A dirty victim causes `wb_req` to rise in the next cycle with `wb_addr` equal to the victim's address. Both are held until `wb_ack`, and the new line is granted in the acknowledge cycle.
- R8: A flush of an address for which the requester owns a dirty copy writes that copy back through the same request and acknowledge path. It is granted in the acknowledge cycle and takes no lock. The line stays valid and becomes clean, so both cores can use it again. A flush with no such copy is granted in the same cycle, with no write-back.
- R9: When a core's own dirty copy and a clean copy of the same address both exist, the core's own dirty copy is selected, whatever the slot numbers.
- R10: A miss made while every slot is locked gives no grant and no write-back until a lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 2 | Request strobe, one bit per core |
| req_write | input | 2 | Per core: 1 = write access, 0 = read access |
| req_flush | input | 2 | Per core: 1 = flush command for the address |
| req_addr | input | 2 x ADDR_W | Line address, one field per core |
| done | input | 2 | One-cycle pulse per core that releases every lock the core holds |
| grant | output | 2 | Grant per core; a requesting core whose bit is low is stalled |
| grant_slot | output | 2 x IDX_W | Granted slot number per core |
| wb_req | output | 1 | Write-back request to the memory side |
| wb_addr | output | ADDR_W | Address of the line being written back |
| wb_ack | input | 1 | Write-back complete |

## Verification
The bench builds the block with four slots and 8-bit addresses. With four slots, a few requests fill the array. This brings the following cases within reach in a short run:
- eviction of clean and dirty victims;
- the fully locked stall;
- duplicate copies created by invisibility;
- preference for an own dirty copy that sits at a higher slot number than a clean copy.

Both arbitration parities are exercised by starting the simultaneous-request case on cycles of opposite parity.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } fsm_e;
endpackage

// File: rtl/ssc_match.sv
module ssc_match #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              core,
    input  logic [NUM_SLOTS-1:0]              valid,
    input  logic [NUM_SLOTS-1:0]              dirty,
    input  logic [NUM_SLOTS-1:0]              owner,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  tag,
    output logic [NUM_SLOTS-1:0]              own_dirty_hit,
    output logic [NUM_SLOTS-1:0]              clean_hit
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic same;
        assign same             = valid[i] && (tag[i] == addr);
        assign own_dirty_hit[i] = same && dirty[i] && (owner[i] == core);
        assign clean_hit[i]     = same && !dirty[i];
    end
endmodule

// File: rtl/ssc_pick.sv
module ssc_pick #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] cand,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        found = |cand;
        idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/shared_slot_ctrl.sv
module shared_slot_ctrl #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  req_valid,
    input  logic [1:0]                  req_write,
    input  logic [1:0]                  req_flush,
    input  logic [1:0][ADDR_W-1:0]      req_addr,
    input  logic [1:0]                  done,
    output logic [1:0]                  grant,
    output logic [1:0][IDX_W-1:0]       grant_slot,
    output logic                        wb_req,
    output logic [ADDR_W-1:0]           wb_addr,
    input  logic                        wb_ack
);
    import ssc_pkg::*;

    typedef struct packed {
        fsm_e                              fsm;
        logic                              prio;
        logic [NUM_SLOTS-1:0]              valid;
        logic [NUM_SLOTS-1:0]              dirty;
        logic [NUM_SLOTS-1:0]              owner;
        logic [NUM_SLOTS-1:0]              lock;
        logic [NUM_SLOTS-1:0]              lock_core;
        logic [NUM_SLOTS-1:0][ADDR_W-1:0]  tag;
        logic                              pend_core;
        logic                              pend_write;
        logic                              pend_flush;
        logic [IDX_W-1:0]                  pend_slot;
        logic [ADDR_W-1:0]                 pend_addr;
    } state_t;

    state_t state_q, state_d;

    // Served core: the priority holder if it asks, else the other one.
    logic              sel;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_write, sel_flush;

    assign sel       = req_valid[state_q.prio] ? state_q.prio : ~state_q.prio;
    assign sel_addr  = req_addr[sel];
    assign sel_write = req_write[sel];
    assign sel_flush = req_flush[sel];

    logic [NUM_SLOTS-1:0] own_hit, clean_hit, free_vec, vict_vec;
    logic                 own_found, clean_found, free_found, vict_found;
    logic [IDX_W-1:0]     own_idx, clean_idx, free_idx, vict_idx;

    ssc_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_match (
        .addr          (sel_addr),
        .core          (sel),
        .valid         (state_q.valid),
        .dirty         (state_q.dirty),
        .owner         (state_q.owner),
        .tag           (state_q.tag),
        .own_dirty_hit (own_hit),
        .clean_hit     (clean_hit)
    );

    assign free_vec = ~state_q.valid & ~state_q.lock;
    assign vict_vec =  state_q.valid & ~state_q.lock;

    ssc_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_own   (.cand(own_hit),   .found(own_found),   .idx(own_idx));
    ssc_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_clean (.cand(clean_hit), .found(clean_found), .idx(clean_idx));
    ssc_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_free  (.cand(free_vec),  .found(free_found),  .idx(free_idx));
    ssc_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick_vict  (.cand(vict_vec),  .found(vict_found),  .idx(vict_idx));

    logic             hit_found;
    logic [IDX_W-1:0] hit_idx;
    assign hit_found = own_found || clean_found;
    assign hit_idx   = own_found ? own_idx : clean_idx;

    function automatic state_t place(state_t s, logic [IDX_W-1:0] idx,
                                     logic [ADDR_W-1:0] a, logic wr, logic core);
        state_t r;
        r                = s;
        r.valid[idx]     = 1'b1;
        r.tag[idx]       = a;
        r.dirty[idx]     = wr;
        r.owner[idx]     = core;
        r.lock[idx]      = 1'b1;
        r.lock_core[idx] = core;
        return r;
    endfunction

    always_comb begin
        state_d      = state_q;
        state_d.prio = ~state_q.prio;
        grant        = '0;
        grant_slot   = '0;
        wb_req       = 1'b0;
        wb_addr      = state_q.tag[state_q.pend_slot];

        // Lock release comes first so a grant in the same cycle keeps its new lock.
        for (int c = 0; c < 2; c++) begin
            if (done[c]) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (state_q.lock_core[i] == 1'(c)) state_d.lock[i] = 1'b0;
                end
            end
        end

        unique case (state_q.fsm)
            ST_IDLE: begin
                if (|req_valid) begin
                    if (sel_flush) begin
                        if (!own_found) begin
                            grant[sel] = 1'b1;
                        end else if (!state_q.lock[own_idx]) begin
                            state_d.fsm        = ST_WB;
                            state_d.pend_core  = sel;
                            state_d.pend_slot  = own_idx;
                            state_d.pend_flush = 1'b1;
                            state_d.pend_write = 1'b0;
                            state_d.pend_addr  = sel_addr;
                        end
                    end else if (hit_found) begin
                        if (!state_q.lock[hit_idx]) begin
                            grant[sel]                = 1'b1;
                            grant_slot[sel]           = hit_idx;
                            state_d.lock[hit_idx]      = 1'b1;
                            state_d.lock_core[hit_idx] = sel;
                            if (sel_write) begin
                                state_d.dirty[hit_idx] = 1'b1;
                                state_d.owner[hit_idx] = sel;
                            end
                        end
                    end else if (free_found) begin
                        grant[sel]      = 1'b1;
                        grant_slot[sel] = free_idx;
                        state_d         = place(state_d, free_idx, sel_addr, sel_write, sel);
                    end else if (vict_found) begin
                        if (state_q.dirty[vict_idx]) begin
                            state_d.fsm        = ST_WB;
                            state_d.pend_core  = sel;
                            state_d.pend_slot  = vict_idx;
                            state_d.pend_flush = 1'b0;
                            state_d.pend_write = sel_write;
                            state_d.pend_addr  = sel_addr;
                        end else begin
                            grant[sel]      = 1'b1;
                            grant_slot[sel] = vict_idx;
                            state_d         = place(state_d, vict_idx, sel_addr, sel_write, sel);
                        end
                    end
                end
            end
            ST_WB: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    state_d.fsm                   = ST_IDLE;
                    grant[state_q.pend_core]      = 1'b1;
                    grant_slot[state_q.pend_core] = state_q.pend_slot;
                    if (state_q.pend_flush) begin
                        state_d.dirty[state_q.pend_slot] = 1'b0;
                    end else begin
                        state_d = place(state_d, state_q.pend_slot, state_q.pend_addr,
                                        state_q.pend_write, state_q.pend_core);
                    end
                end
            end
            default: state_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        req_valid,
    input logic [1:0]        grant,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack
);
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        !(grant[0] && grant[1]));                                          // R6

    AST_GRANT_NEEDS_REQ0: assert property (@(posedge clk) disable iff (rst)
        grant[0] |-> req_valid[0]);                                        // R2

    AST_GRANT_NEEDS_REQ1: assert property (@(posedge clk) disable iff (rst)
        grant[1] |-> req_valid[1]);                                        // R2

    AST_WB_HELD: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));             // R7

    AST_NO_GRANT_WHILE_WB: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |-> (grant == 2'b00));                         // R8

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wb_req);                                           // R1
endmodule

bind shared_slot_ctrl ssc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .grant     (grant),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .wb_ack    (wb_ack)
);

// File: tb/shared_slot_ctrl_tb.sv
module shared_slot_ctrl_tb;
    localparam int NS = 4;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      req_valid = '0, req_write = '0, req_flush = '0, done = '0;
    logic [1:0][AW-1:0] req_addr = '0;
    logic [1:0]      grant;
    logic [1:0][1:0] grant_slot;
    logic            wb_req;
    logic [AW-1:0]   wb_addr;
    logic            wb_ack = 1'b0;

    int total = 0;
    int bad   = 0;
    int edges = 0;

    shared_slot_ctrl #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_flush(req_flush), .req_addr(req_addr), .done(done),
        .grant(grant), .grant_slot(grant_slot), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_ack(wb_ack)
    );

    always #5 clk = ~clk;

    // Arbitration model: priority bit starts at core 0 and flips on every edge out of reset.
    always @(posedge clk) if (!rst) edges <= edges + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    typedef struct packed {
        logic       core;
        logic       wr;
        logic       fl;
        logic [7:0] addr;
        logic [1:0] slot;
        logic       wb;
        logic [7:0] wba;
        logic       chk_slot;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 4'd2}, // R2 first read, slot 0
        '{1'b1, 1'b0, 1'b0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 4'd3}, // R3 shared clean read
        '{1'b0, 1'b1, 1'b0, 8'h20, 2'd1, 1'b0, 8'h00, 1'b1, 4'd2}, // R2 write miss, free slot
        '{1'b1, 1'b0, 1'b0, 8'h20, 2'd2, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 other's dirty hidden
        '{1'b1, 1'b1, 1'b0, 8'h10, 2'd0, 1'b0, 8'h00, 1'b1, 4'd3}, // R3 write on clean
        '{1'b0, 1'b0, 1'b0, 8'h10, 2'd3, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 now hidden from core 0
        '{1'b1, 1'b0, 1'b1, 8'h10, 2'd0, 1'b1, 8'h10, 1'b1, 4'd8}, // R8 flush writes back
        '{1'b0, 1'b0, 1'b1, 8'h20, 2'd1, 1'b1, 8'h20, 1'b1, 4'd8}, // R8 flush writes back
        '{1'b1, 1'b1, 1'b0, 8'h20, 2'd1, 1'b0, 8'h00, 1'b1, 4'd8}, // R8 flushed line kept clean
        '{1'b0, 1'b1, 1'b0, 8'h20, 2'd2, 1'b0, 8'h00, 1'b1, 4'd4}, // R4 core 1 dirty hidden
        '{1'b1, 1'b0, 1'b1, 8'h20, 2'd1, 1'b1, 8'h20, 1'b1, 4'd8}, // R8 flush
        '{1'b0, 1'b0, 1'b0, 8'h20, 2'd2, 1'b0, 8'h00, 1'b1, 4'd9}, // R9 own dirty over lower clean
        '{1'b0, 1'b0, 1'b1, 8'h10, 2'd0, 1'b0, 8'h00, 1'b0, 4'd8}, // R8 nothing to flush
        '{1'b1, 1'b0, 1'b0, 8'h30, 2'd0, 1'b0, 8'h00, 1'b1, 4'd7}, // R7 clean victim
        '{1'b0, 1'b1, 1'b0, 8'h40, 2'd0, 1'b0, 8'h00, 1'b1, 4'd7}, // R7 clean victim, write
        '{1'b1, 1'b0, 1'b0, 8'h50, 2'd0, 1'b1, 8'h40, 1'b1, 4'd7}  // R7 dirty victim
    };

    task automatic xact(input logic c, input logic wr, input logic fl, input logic [7:0] a,
                        input logic do_done, output logic got, output logic [1:0] slot,
                        output logic saw_wb, output logic [7:0] wba);
        logic ack_next;
        got = 1'b0; slot = '0; saw_wb = 1'b0; wba = '0;
        @(negedge clk);
        req_valid[c] = 1'b1; req_write[c] = wr; req_flush[c] = fl; req_addr[c] = a;
        for (int k = 0; k < 12; k++) begin
            #4;
            ack_next = wb_req && !wb_ack;
            if (wb_req) begin saw_wb = 1'b1; wba = wb_addr; end
            if (grant[c]) begin got = 1'b1; slot = grant_slot[c]; end
            @(negedge clk);
            wb_ack = ack_next;
            if (got) break;
        end
        req_valid[c] = 1'b0; req_write[c] = 1'b0; req_flush[c] = 1'b0; wb_ack = 1'b0;
        if (do_done && got) begin
            done[c] = 1'b1;
            @(negedge clk);
            done[c] = 1'b0;
        end
    endtask

    task automatic dual(input logic [7:0] a0, input logic [7:0] a1, output logic w);
        logic p;
        @(negedge clk);
        req_valid = 2'b11; req_write = 2'b00; req_flush = 2'b00;
        req_addr[0] = a0; req_addr[1] = a1;
        #4;
        p = edges[0];
        check("R6 one grant to priority core", 32'(grant), p ? 32'h2 : 32'h1);
        check("R6 winner victim slot", 32'(grant_slot[p]), 32'd0);
        w = p;
        @(negedge clk);
        req_valid[p] = 1'b0;
        #4;
        check("R6 loser served next", 32'(grant[!p]), 32'd1);
        check("R6 loser slot", 32'(grant_slot[!p]), 32'd1);
        @(negedge clk);
        req_valid = 2'b00;
        done = 2'b11;
        @(negedge clk);
        done = 2'b00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        summary();
    end

    initial begin
        logic       got, saw_wb, w1, w2;
        logic [1:0] slot;
        logic [7:0] wba;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        check("R1 no write-back after reset", 32'(wb_req), 32'd0);
        check("R1 no grant after reset", 32'(grant), 32'd0);

        for (int v = 0; v < NV; v++) begin
            xact(VEC[v].core, VEC[v].wr, VEC[v].fl, VEC[v].addr, !VEC[v].fl,
                 got, slot, saw_wb, wba);
            check($sformatf("R%0d vec%0d granted", VEC[v].rq, v), 32'(got), 32'd1);
            if (VEC[v].chk_slot)
                check($sformatf("R%0d vec%0d slot", VEC[v].rq, v), 32'(slot), 32'(VEC[v].slot));
            check($sformatf("R%0d vec%0d write-back seen", VEC[v].rq, v), 32'(saw_wb), 32'(VEC[v].wb));
            if (VEC[v].wb)
                check($sformatf("R%0d vec%0d wb_addr", VEC[v].rq, v), 32'(wba), 32'(VEC[v].wba));
        end
        // Slots now: 0 clean 50, 1 clean 20, 2 dirty(core0) 20, 3 clean 10.

        // R5: core 1 locks slot 3, core 0 stalls on it until core 1 is done.
        xact(1'b1, 1'b0, 1'b0, 8'h10, 1'b0, got, slot, saw_wb, wba);
        check("R5 holder slot", 32'(slot), 32'd3);
        @(negedge clk);
        req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0] = 8'h10;
        for (int k = 0; k < 3; k++) begin
            #4;
            check("R5 stalled on locked slot", 32'(grant[0]), 32'd0);
            @(negedge clk);
        end
        done[1] = 1'b1;
        #4;
        check("R5 still stalled in done cycle", 32'(grant[0]), 32'd0);
        @(negedge clk);
        done[1] = 1'b0;
        #4;
        check("R5 granted after done", 32'(grant[0]), 32'd1);
        check("R5 slot after done", 32'(grant_slot[0]), 32'd3);
        @(negedge clk);
        req_valid[0] = 1'b0;
        done[0] = 1'b1;
        @(negedge clk);
        done[0] = 1'b0;

        // R10: lock all four slots, then a miss must stall without write-back.
        xact(1'b0, 1'b0, 1'b0, 8'h50, 1'b0, got, slot, saw_wb, wba);
        check("R10 setup slot0", 32'(slot), 32'd0);
        xact(1'b0, 1'b0, 1'b0, 8'h20, 1'b0, got, slot, saw_wb, wba);
        check("R9 own dirty chosen", 32'(slot), 32'd2);
        xact(1'b1, 1'b0, 1'b0, 8'h20, 1'b0, got, slot, saw_wb, wba);
        check("R4 clean copy for other core", 32'(slot), 32'd1);
        xact(1'b1, 1'b0, 1'b0, 8'h10, 1'b0, got, slot, saw_wb, wba);
        check("R10 setup slot3", 32'(slot), 32'd3);
        @(negedge clk);
        req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0] = 8'h60;
        for (int k = 0; k < 3; k++) begin
            #4;
            check("R10 no grant when all locked", 32'(grant[0]), 32'd0);
            check("R10 no write-back when all locked", 32'(wb_req), 32'd0);
            @(negedge clk);
        end
        done[0] = 1'b1;
        @(negedge clk);
        done[0] = 1'b0;
        #4;
        check("R7 victim after release", 32'(grant[0]), 32'd1);
        check("R7 lowest unlocked victim", 32'(grant_slot[0]), 32'd0);
        @(negedge clk);
        req_valid[0] = 1'b0;
        done = 2'b11;
        @(negedge clk);
        done = 2'b00;

        // R6: simultaneous requests, started on opposite cycle parities.
        dual(8'h70, 8'h80, w1);
        @(negedge clk);
        if (edges[0] != w1) @(negedge clk);
        dual(8'h90, 8'hA0, w2);
        check("R6 winner alternates", 32'(w2), 32'(!w1));

        summary();
    end
endmodule